// File: doc/BRIEF.md
# Programmable product-term transition array

This block is the combinational decision logic of a configurable Mealy sequencer. It forms 64 product terms from 16 external inputs and 8 fed-back present-state bits. Each term may also use the result of either of two complement arrays. It then routes the active terms through a programmable OR plane into J and K commands for 16 flip-flops: 8 state and 8 output. The flip-flops themselves live outside the block. The block receives their state on `state_i` and returns the J/K commands for the next edge.

Each complement array is a single NOR over the terms that are marked as feeding it. Its output is high only when none of those terms is active. Other terms can take that result as an extra literal. This gives an "else" branch or an illegal-state catch-all at the cost of one product term. The two arrays are independent, so two sub-machines can each have their own default branch.

All programming is held in one configuration word per term. A word is written through a write port that takes an index and the data. Any word can be read back through a separate combinational read port. Reset clears every word. A term that would both feed a complement array and consume one is a combinational loop. Such a term is forced inactive and reported on `cfg_loop_o`.

Top module: `pla_seq_logic`

## Requirements
- R1: After reset every configuration word reads zero, every term is inactive, `ca_o` is all ones, `j_o` and `k_o` are zero and `cfg_loop_o` is low, whatever the inputs.
- R2: When `cfg_we_i` is high at a rising clock edge, word `cfg_waddr_i` takes `cfg_wdata_i`. `cfg_rdata_o` shows the stored word at `cfg_raddr_i` combinationally. Outputs reflect a write only after that edge. The word layout is: literal codes in bits [47:0], complement codes in bits [51:48], OR codes in bits [83:52].
- R3: Variable v (0..15 = `in_i[v]`, 16..23 = `state_i[v-16]`) has the 2-bit code at word bits [2v+1:2v]. The codes are: 00 forces the term to 0, 01 uses the true value, 10 uses the complement, 11 ignores the variable.
- R4: Complement array c (0 or 1) has the 2-bit term code at bits [49+2c:48+2c]. The codes are: 00 no connection, 01 the term feeds the array, 10 the term uses the array output. `ca_o[c]` is 1 exactly when no term coded 01 for c is active.
- R5: A term coded 10 for array c is active only when its literals match and `ca_o[c]` is 1.
- R6: A term whose complement codes both feed some array and use some array is forced to 0, and `cfg_loop_o` is high while any stored word is in that state. This includes code 11 on one array, and 01 on one array with 10 on the other.
- R7: Register r (0..7 state, 8..15 output) has the 2-bit OR code at bits [53+2r:52+2r]. The codes are: 00 drives nothing, 01 drives J, 10 drives K, 11 (toggle) drives both. `j_o[r]` and `k_o[r]` are the OR of the active terms so connected. One term may drive any number of registers.
- R8: The two complement arrays are independent. A term feeding only array 1 never changes `ca_o[0]`, and the reverse also holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock for configuration writes |
| rst_ni | input | 1 | Active-low asynchronous reset, clears configuration |
| cfg_we_i | input | 1 | Configuration write enable |
| cfg_waddr_i | input | 6 | Term index to write |
| cfg_wdata_i | input | 84 | Configuration word to write |
| cfg_raddr_i | input | 6 | Term index to read |
| cfg_rdata_o | output | 84 | Stored word at the read index |
| in_i | input | 16 | External inputs |
| state_i | input | 8 | Present-state feedback |
| term_o | output | 64 | Product-term activity |
| ca_o | output | 2 | Complement array outputs |
| j_o | output | 16 | J commands, state regs 0..7, output regs 8..15 |
| k_o | output | 16 | K commands, same order |
| cfg_loop_o | output | 1 | Some stored term forms a complement loop |

## Verification
A configuration write and the evaluation of that same term can fall in one cycle. The bench rewrites a term that is firing while the inputs are held steady. It samples the outputs before the write edge and expects the old routing. It samples again after the edge and expects the new routing. A second overlap is a term that feeds one complement array while a neighbour consumes it. In that case the array output and the consuming term must flip together on the same input change. Directed patterns and many random configurations with biased literal counts provoke this. A bench model built from the requirements judges every sample.

// File: rtl/pla_seq_pkg.sv
package pla_seq_pkg;
  typedef enum logic [1:0] {
    AV_OFF  = 2'b00,
    AV_TRUE = 2'b01,
    AV_COMP = 2'b10,
    AV_DC   = 2'b11
  } and_code_e;

  typedef enum logic [1:0] {
    CA_NONE = 2'b00,
    CA_GEN  = 2'b01,
    CA_PROP = 2'b10,
    CA_BOTH = 2'b11
  } ca_code_e;

  typedef enum logic [1:0] {
    OR_NONE = 2'b00,
    OR_SET  = 2'b01,
    OR_RST  = 2'b10,
    OR_TGL  = 2'b11
  } or_code_e;
endpackage

// File: rtl/pla_cfg_store.sv
module pla_cfg_store #(
  parameter int unsigned N_TERM = 64,
  parameter int unsigned WORD_W = 84,
  localparam int unsigned AW = $clog2(N_TERM)
) (
  input  logic                             clk_i,
  input  logic                             rst_ni,
  input  logic                             we_i,
  input  logic [AW-1:0]                    waddr_i,
  input  logic [WORD_W-1:0]                wdata_i,
  input  logic [AW-1:0]                    raddr_i,
  output logic [WORD_W-1:0]                rdata_o,
  output logic [N_TERM-1:0][WORD_W-1:0]    cfg_o
);
  logic [N_TERM-1:0][WORD_W-1:0] mem_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mem_q <= '0;
    end else if (we_i && (32'(waddr_i) < N_TERM)) begin
      mem_q[waddr_i] <= wdata_i;
    end
  end

  assign rdata_o = (32'(raddr_i) < N_TERM) ? mem_q[raddr_i] : '0;
  assign cfg_o   = mem_q;
endmodule

// File: rtl/pla_term_and.sv
module pla_term_and
  import pla_seq_pkg::*;
#(
  parameter int unsigned N_VAR = 24,
  parameter int unsigned N_CA  = 2
) (
  input  logic [N_VAR-1:0]   var_i,
  input  logic [2*N_VAR-1:0] and_code_i,
  input  logic [2*N_CA-1:0]  ca_code_i,
  output logic               base_o,
  output logic [N_CA-1:0]    gen_o,
  output logic [N_CA-1:0]    prop_o,
  output logic               loop_o
);
  logic hit;

  always_comb begin
    hit = 1'b1;
    for (int v = 0; v < N_VAR; v++) begin
      case (and_code_e'(and_code_i[2*v +: 2]))
        AV_OFF:  hit = 1'b0;
        AV_TRUE: hit = hit & var_i[v];
        AV_COMP: hit = hit & ~var_i[v];
        default: ;
      endcase
    end
  end

  always_comb begin
    for (int c = 0; c < N_CA; c++) begin
      gen_o[c]  = (ca_code_e'(ca_code_i[2*c +: 2]) == CA_GEN)  ||
                  (ca_code_e'(ca_code_i[2*c +: 2]) == CA_BOTH);
      prop_o[c] = (ca_code_e'(ca_code_i[2*c +: 2]) == CA_PROP) ||
                  (ca_code_e'(ca_code_i[2*c +: 2]) == CA_BOTH);
    end
  end

  // feeding and consuming in one term would close a combinational loop
  assign loop_o = (|gen_o) & (|prop_o);
  assign base_o = hit & ~loop_o;
endmodule

// File: rtl/pla_comp_array.sv
module pla_comp_array #(
  parameter int unsigned N_TERM = 64
) (
  input  logic [N_TERM-1:0] base_i,
  input  logic [N_TERM-1:0] gen_i,
  output logic              ca_o
);
  assign ca_o = ~|(base_i & gen_i);
endmodule

// File: rtl/pla_or_plane.sv
module pla_or_plane #(
  parameter int unsigned N_TERM = 64,
  parameter int unsigned N_REG  = 16
) (
  input  logic [N_TERM-1:0]                term_i,
  input  logic [N_TERM-1:0][2*N_REG-1:0]   or_code_i,
  output logic [N_REG-1:0]                 j_o,
  output logic [N_REG-1:0]                 k_o
);
  always_comb begin
    j_o = '0;
    k_o = '0;
    for (int t = 0; t < N_TERM; t++) begin
      for (int r = 0; r < N_REG; r++) begin
        j_o[r] = j_o[r] | (term_i[t] & or_code_i[t][2*r]);
        k_o[r] = k_o[r] | (term_i[t] & or_code_i[t][2*r+1]);
      end
    end
  end
endmodule

// File: rtl/pla_seq_logic.sv
module pla_seq_logic #(
  parameter int unsigned N_IN   = 16,
  parameter int unsigned N_ST   = 8,
  parameter int unsigned N_OUT  = 8,
  parameter int unsigned N_TERM = 64,
  parameter int unsigned N_CA   = 2,
  localparam int unsigned N_VAR  = N_IN + N_ST,
  localparam int unsigned N_REG  = N_ST + N_OUT,
  localparam int unsigned AND_W  = 2 * N_VAR,
  localparam int unsigned CA_W   = 2 * N_CA,
  localparam int unsigned OR_W   = 2 * N_REG,
  localparam int unsigned WORD_W = AND_W + CA_W + OR_W,
  localparam int unsigned AW     = $clog2(N_TERM)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_we_i,
  input  logic [AW-1:0]     cfg_waddr_i,
  input  logic [WORD_W-1:0] cfg_wdata_i,
  input  logic [AW-1:0]     cfg_raddr_i,
  output logic [WORD_W-1:0] cfg_rdata_o,
  input  logic [N_IN-1:0]   in_i,
  input  logic [N_ST-1:0]   state_i,
  output logic [N_TERM-1:0] term_o,
  output logic [N_CA-1:0]   ca_o,
  output logic [N_REG-1:0]  j_o,
  output logic [N_REG-1:0]  k_o,
  output logic              cfg_loop_o
);
  logic [N_TERM-1:0][WORD_W-1:0] cfg;
  logic [N_TERM-1:0][OR_W-1:0]   or_code;
  logic [N_TERM-1:0]             base, loop;
  logic [N_TERM-1:0][N_CA-1:0]   gen, prop;
  logic [N_CA-1:0][N_TERM-1:0]   gen_by_ca;
  logic [N_VAR-1:0]              vars;

  assign vars = {state_i, in_i};

  pla_cfg_store #(.N_TERM(N_TERM), .WORD_W(WORD_W)) u_store (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (cfg_we_i),
    .waddr_i (cfg_waddr_i),
    .wdata_i (cfg_wdata_i),
    .raddr_i (cfg_raddr_i),
    .rdata_o (cfg_rdata_o),
    .cfg_o   (cfg)
  );

  for (genvar t = 0; t < N_TERM; t++) begin : g_term
    pla_term_and #(.N_VAR(N_VAR), .N_CA(N_CA)) u_and (
      .var_i      (vars),
      .and_code_i (cfg[t][AND_W-1:0]),
      .ca_code_i  (cfg[t][AND_W +: CA_W]),
      .base_o     (base[t]),
      .gen_o      (gen[t]),
      .prop_o     (prop[t]),
      .loop_o     (loop[t])
    );
    assign or_code[t] = cfg[t][AND_W+CA_W +: OR_W];
    // consuming terms see the NOR only; feeding terms never consume (loop rule)
    assign term_o[t]  = base[t] & (&(ca_o | ~prop[t]));
  end

  for (genvar c = 0; c < N_CA; c++) begin : g_ca
    for (genvar t = 0; t < N_TERM; t++) begin : g_tr
      assign gen_by_ca[c][t] = gen[t][c];
    end
    pla_comp_array #(.N_TERM(N_TERM)) u_ca (
      .base_i (base),
      .gen_i  (gen_by_ca[c]),
      .ca_o   (ca_o[c])
    );
  end

  pla_or_plane #(.N_TERM(N_TERM), .N_REG(N_REG)) u_or (
    .term_i    (term_o),
    .or_code_i (or_code),
    .j_o       (j_o),
    .k_o       (k_o)
  );

  assign cfg_loop_o = |loop;
endmodule

// File: rtl/pla_seq_logic_chk.sv
module pla_seq_logic_chk #(
  parameter int unsigned N_TERM = 64,
  parameter int unsigned N_CA   = 2,
  parameter int unsigned N_REG  = 16,
  parameter int unsigned WORD_W = 84,
  parameter int unsigned AW     = 6
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              cfg_we_i,
  input logic [AW-1:0]     cfg_waddr_i,
  input logic [WORD_W-1:0] cfg_wdata_i,
  input logic [AW-1:0]     cfg_raddr_i,
  input logic [WORD_W-1:0] cfg_rdata_o,
  input logic [N_TERM-1:0] term_o,
  input logic [N_CA-1:0]   ca_o,
  input logic [N_REG-1:0]  j_o,
  input logic [N_REG-1:0]  k_o,
  input logic              cfg_loop_o
);
  logic past_ok, wrote;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      past_ok <= 1'b0;
      wrote   <= 1'b0;
    end else begin
      past_ok <= 1'b1;
      if (cfg_we_i) wrote <= 1'b1;
    end
  end

  p_reset_clean_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wrote |-> (term_o == '0 && ca_o == '1 && j_o == '0 && k_o == '0 && !cfg_loop_o));

  p_write_visible_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (past_ok && $past(cfg_we_i) && cfg_raddr_i == $past(cfg_waddr_i))
      |-> cfg_rdata_o == $past(cfg_wdata_i));

  p_read_steady_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (past_ok && !$past(cfg_we_i) && $stable(cfg_raddr_i)) |-> $stable(cfg_rdata_o));

  p_nor_needs_term_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ca_o != '1) |-> (term_o != '0));

  p_idle_no_cmd_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (term_o == '0) |-> (j_o == '0 && k_o == '0));
endmodule

bind pla_seq_logic pla_seq_logic_chk #(
  .N_TERM(N_TERM), .N_CA(N_CA), .N_REG(N_REG), .WORD_W(WORD_W), .AW(AW)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .cfg_we_i    (cfg_we_i),
  .cfg_waddr_i (cfg_waddr_i),
  .cfg_wdata_i (cfg_wdata_i),
  .cfg_raddr_i (cfg_raddr_i),
  .cfg_rdata_o (cfg_rdata_o),
  .term_o      (term_o),
  .ca_o        (ca_o),
  .j_o         (j_o),
  .k_o         (k_o),
  .cfg_loop_o  (cfg_loop_o)
);

// File: tb/pla_seq_logic_tb.sv
module pla_seq_logic_tb_top;
  localparam int NT = 64, NI = 16, NS = 8, NV = 24, NC = 2, NR = 16;
  localparam int AND_W = 2*NV, CA_W = 2*NC, OR_W = 2*NR;
  localparam int W = AND_W + CA_W + OR_W;

  logic clk = 1'b0, rst_n = 1'b0;
  logic we = 1'b0;
  logic [5:0] waddr = '0, raddr = '0;
  logic [W-1:0] wdata = '0, rdata;
  logic [NI-1:0] in_v = '0;
  logic [NS-1:0] st_v = '0;
  logic [NT-1:0] term;
  logic [NC-1:0] ca;
  logic [NR-1:0] jv, kv;
  logic loop_f;

  int n_chk = 0, n_err = 0;
  bit done = 0;

  logic [W-1:0] mdl [NT];
  logic [NT-1:0] e_term;
  logic [NC-1:0] e_ca;
  logic [NR-1:0] e_j, e_k;
  logic e_loop;

  always #2.5 clk = ~clk;

  pla_seq_logic dut_i (
    .clk_i(clk), .rst_ni(rst_n), .cfg_we_i(we), .cfg_waddr_i(waddr),
    .cfg_wdata_i(wdata), .cfg_raddr_i(raddr), .cfg_rdata_o(rdata),
    .in_i(in_v), .state_i(st_v), .term_o(term), .ca_o(ca),
    .j_o(jv), .k_o(kv), .cfg_loop_o(loop_f)
  );

  task automatic chk(string req, string what, logic [127:0] act, logic [127:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic logic [W-1:0] s_and(logic [W-1:0] w, int v, logic [1:0] c);
    w[2*v +: 2] = c; return w;
  endfunction
  function automatic logic [W-1:0] s_ca(logic [W-1:0] w, int a, logic [1:0] c);
    w[AND_W + 2*a +: 2] = c; return w;
  endfunction
  function automatic logic [W-1:0] s_or(logic [W-1:0] w, int r, logic [1:0] c);
    w[AND_W + CA_W + 2*r +: 2] = c; return w;
  endfunction
  function automatic logic [W-1:0] all_dc();
    logic [W-1:0] w = '0;
    w[AND_W-1:0] = '1; return w;
  endfunction

  // reference model from the requirements
  task automatic model();
    logic [NV-1:0] vv;
    logic [NT-1:0] base;
    vv = {st_v, in_v};
    e_loop = 1'b0;
    for (int t = 0; t < NT; t++) begin
      logic hit, g, p;
      hit = 1'b1;
      for (int v = 0; v < NV; v++) begin
        case (mdl[t][2*v +: 2])
          2'b00: hit = 1'b0;
          2'b01: if (!vv[v]) hit = 1'b0;
          2'b10: if (vv[v]) hit = 1'b0;
          default: ;
        endcase
      end
      g = 1'b0; p = 1'b0;
      for (int a = 0; a < NC; a++) begin
        g |= mdl[t][AND_W + 2*a];
        p |= mdl[t][AND_W + 2*a + 1];
      end
      if (g && p) begin hit = 1'b0; e_loop = 1'b1; end
      base[t] = hit;
    end
    for (int a = 0; a < NC; a++) begin
      e_ca[a] = 1'b1;
      for (int t = 0; t < NT; t++)
        if (base[t] && mdl[t][AND_W + 2*a]) e_ca[a] = 1'b0;
    end
    e_j = '0; e_k = '0;
    for (int t = 0; t < NT; t++) begin
      e_term[t] = base[t];
      for (int a = 0; a < NC; a++)
        if (mdl[t][AND_W + 2*a + 1] && !e_ca[a]) e_term[t] = 1'b0;
      for (int r = 0; r < NR; r++) begin
        if (e_term[t] && mdl[t][AND_W + CA_W + 2*r])     e_j[r] = 1'b1;
        if (e_term[t] && mdl[t][AND_W + CA_W + 2*r + 1]) e_k[r] = 1'b1;
      end
    end
  endtask

  task automatic cmp(string req);
    model();
    chk(req, "term", 128'(term), 128'(e_term));
    chk(req, "ca",   128'(ca),   128'(e_ca));
    chk(req, "j",    128'(jv),   128'(e_j));
    chk(req, "k",    128'(kv),   128'(e_k));
    chk(req, "loop", 128'(loop_f), 128'(e_loop));
  endtask

  task automatic drive(logic [NI-1:0] i, logic [NS-1:0] s, string req);
    @(negedge clk);
    in_v = i; st_v = s;
    #1 cmp(req);
  endtask

  task automatic wr(int idx, logic [W-1:0] d);
    @(negedge clk);
    we = 1'b1; waddr = 6'(idx); wdata = d;
    @(negedge clk);
    we = 1'b0;
    mdl[idx] = d;
    raddr = 6'(idx);
    #1 chk("R2", "readback", 128'(rdata), 128'(d));
  endtask

  task automatic clear_all();
    for (int t = 0; t < NT; t++) wr(t, '0);
  endtask

  function automatic logic [W-1:0] rnd_word();
    logic [W-1:0] w;
    w = '0;
    for (int v = 0; v < NV; v++) begin
      int r = int'($urandom % 24);
      w[2*v +: 2] = (r == 0) ? 2'b01 : (r == 1) ? 2'b10 : 2'b11;
    end
    if ($urandom % 8 == 0) w[2*($urandom % NV) +: 2] = 2'b00;
    for (int a = 0; a < NC; a++) begin
      int r = int'($urandom % 8);
      w[AND_W + 2*a +: 2] = (r == 0) ? 2'b01 : (r == 1) ? 2'b10 :
                            (r == 2 && $urandom % 4 == 0) ? 2'b11 : 2'b00;
    end
    w[AND_W + CA_W +: OR_W] = OR_W'($urandom);
    return w;
  endfunction

  initial begin
    #1_000_000;
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("  Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    logic [W-1:0] w;
    void'($urandom(32'h5eed));
    for (int t = 0; t < NT; t++) mdl[t] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: reset state
    raddr = 6'd0;  #1 chk("R1", "rdata0", 128'(rdata), 128'(0));
    raddr = 6'd63; #1 chk("R1", "rdata63", 128'(rdata), 128'(0));
    drive(16'hffff, 8'hff, "R1");
    drive(16'h1234, 8'h5a, "R1");
    chk("R1", "ca_all_ones", 128'(ca), 128'(2'b11));

    // R3: literal codes
    w = s_or(s_and(s_and(all_dc(), 3, 2'b01), 18, 2'b10), 0, 2'b01);
    wr(5, w);
    drive(16'h0008, 8'h00, "R3");
    chk("R3", "j0_set", 128'(jv[0]), 128'(1));
    drive(16'h0000, 8'h00, "R3");
    chk("R3", "t5_off", 128'(term[5]), 128'(0));
    drive(16'h0008, 8'h04, "R3");
    wr(6, s_or(s_and(all_dc(), 10, 2'b00), 1, 2'b11));
    drive(16'hffff, 8'h00, "R3");
    chk("R3", "unprog_off", 128'(term[6]), 128'(0));

    // same-cycle write vs evaluation: term 5 rerouted to K of reg 9
    @(negedge clk);
    in_v = 16'h0008; st_v = 8'h00;
    we = 1'b1; waddr = 6'd5;
    wdata = s_or(s_and(s_and(all_dc(), 3, 2'b01), 18, 2'b10), 9, 2'b10);
    #1 cmp("R2");
    chk("R2", "old_j0", 128'(jv[0]), 128'(1));
    @(negedge clk);
    we = 1'b0; mdl[5] = wdata;
    #1 cmp("R2");
    chk("R2", "new_k9", 128'(kv[9]), 128'(1));
    chk("R2", "new_j0", 128'(jv[0]), 128'(0));

    // R4/R5: default branch on array 0
    clear_all();
    wr(0, s_ca(s_and(all_dc(), 0, 2'b01), 0, 2'b01));
    wr(1, s_or(s_ca(all_dc(), 0, 2'b10), 3, 2'b01));
    drive(16'h0000, 8'h00, "R4");
    chk("R5", "else_j3", 128'(jv[3]), 128'(1));
    drive(16'h0001, 8'h00, "R5");
    chk("R4", "ca0_low", 128'(ca[0]), 128'(0));
    chk("R5", "else_off", 128'(term[1]), 128'(0));

    // R8: array 1 independent
    wr(2, s_ca(s_and(all_dc(), 1, 2'b01), 1, 2'b01));
    drive(16'h0002, 8'h00, "R8");
    chk("R8", "ca", 128'(ca), 128'(2'b01));

    // R6: loops
    wr(7, s_or(s_ca(all_dc(), 0, 2'b11), 2, 2'b01));
    drive(16'h0000, 8'h00, "R6");
    chk("R6", "flag_same", 128'(loop_f), 128'(1));
    chk("R6", "t7_forced", 128'(term[7]), 128'(0));
    wr(7, s_ca(s_ca(all_dc(), 0, 2'b01), 1, 2'b10));
    drive(16'h0000, 8'h00, "R6");
    chk("R6", "flag_cross", 128'(loop_f), 128'(1));
    wr(7, '0);
    drive(16'h0000, 8'h00, "R6");
    chk("R6", "flag_clear", 128'(loop_f), 128'(0));

    // R7: toggle and reset routing, one term to many registers
    wr(8, s_or(s_or(s_or(all_dc(), 12, 2'b11), 4, 2'b10), 15, 2'b01));
    drive(16'h0000, 8'h00, "R7");
    chk("R7", "j", 128'(jv & 16'h9010), 128'(16'h9000));
    chk("R7", "k", 128'(kv & 16'h1010), 128'(16'h1010));

    // random configurations
    for (int round = 0; round < 40; round++) begin
      for (int n = 0; n < 8; n++) wr(int'($urandom % NT), rnd_word());
      for (int n = 0; n < 20; n++) drive(NI'($urandom), NS'($urandom), "R7");
    end

    done = 1;
    $display("  Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule